// File: doc/BRIEF.md
# Clock output gating controller

This block sits between the dividers of a multi-output clock generator and its output drivers. For every output it decides, once per reference cycle, whether the output toggles (run), is driven low (low) or is released (tri-state). The decision depends on register fields and on an external power-down request. The register fields are a per-output enable, a per-output free-running or stoppable choice for the SRC pairs and the free-running PCI clocks, idle drive-mode bits, and an active-low stop bit. Each output's divider supplies a phase input. That input is high while the divided clock is high. A new gating decision is applied only at a reference edge where that phase is low, so no output can emit a runt pulse.

The stop bit and the power-down request are re-timed through two flip-flops each before use. Power-down is handled in four steps. First, every output is forced to its power-down mode. Next, the controller waits until all outputs have settled. Only then does it raise the shut-off requests for all three PLLs. On release the PLLs are turned back on and every enabled output is driven low for a programmable lock interval. After that interval, normal gating resumes. Each PLL can also be shut off directly through its own register bit.

Outputs are numbered in a fixed order. Indices 0..NUM_CPU-1 are the CPU pairs. The SRC pairs come next (NUM_SRC), then the free-running PCI clocks (NUM_PCIF), then the plain PCI clocks (NUM_PCI), then the REF outputs (NUM_REF). The next index is the 48 MHz output and the last index is the 96 MHz pair. With the default parameters these are CPU 0-1, SRC 2-9, PCIF 10-12, PCI 13-18, REF 19-20, 48 MHz 21 and 96 MHz 22.

Top module: `clkgate_ctrl`

## Requirements
- R1: For every output index, exactly one of `run_o`, `low_o`, `hiz_o` is set, and the index order is the one given above (CPU, SRC, PCIF, PCI, REF, 48 MHz, 96 MHz).
- R2: An output whose `out_en_i` bit is 0 goes to tri-state in every situation (running, stopped, powered down, waking).
- R3: While `stop_n_i` is 0 and no power-down is in progress, the following outputs change mode; every other output keeps running:
  - an SRC pair whose stoppable bit is 1 goes tri-state if `src_stop_tri_i` is 1 and low if it is 0;
  - a PCIF clock whose stoppable bit is 1 goes low;
  - every plain PCI clock goes low;
  - a stoppable bit of 0 keeps that output running, and CPU, REF, 48 MHz and 96 MHz outputs ignore the stop bit.
- R4: An output changes mode only at a clock edge where its `phase_i` bit was sampled low. While `phase_i` stays high, the output keeps its mode.
- R5: During power-down, the stop bit is ignored and each enabled output takes its power-down mode:
  - each CPU pair follows its own `cpu_pd_tri_i` bit;
  - all SRC pairs follow `src_pd_tri_i`;
  - the 96 MHz pair follows `dot_pd_tri_i`;
  - in each of these drive-mode bits, 1 means tri-state and 0 means low;
  - PCIF, PCI and REF outputs go low, and the 48 MHz output goes tri-state.
- R6: All three `pll_off_o` bits rise only after every output has reached its power-down mode, and no output is in run while the PLLs are shut off.
- R7: After the power-down request is released, `pll_off_o` returns to `pll_pd_i`. Every enabled output, including one that was tri-stated, is then driven low for LOCK_CYC cycles before normal gating resumes.
- R8: Reset puts every output in low with `pll_off_o` equal to `pll_pd_i`, and then runs the same lock interval as R7 before outputs start running.
- R9: `pll_off_o[0]` (CPU PLL), `pll_off_o[1]` (SRC PLL) and `pll_off_o[2]` (48/96 MHz PLL) are each set whenever the matching `pll_pd_i` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | NOUT | Per-output divided-clock level, high while that clock is high |
| out_en_i | input | NOUT | Per-output enable, 0 tri-states the output |
| src_stoppable_i | input | NUM_SRC | 1 makes that SRC pair follow the stop bit |
| pcif_stoppable_i | input | NUM_PCIF | 1 makes that PCIF clock follow the stop bit |
| stop_n_i | input | 1 | Active-low stop of stoppable PCI/SRC clocks |
| src_stop_tri_i | input | 1 | Stopped SRC pairs: 1 tri-state, 0 low |
| cpu_pd_tri_i | input | NUM_CPU | Power-down mode per CPU pair: 1 tri-state, 0 low |
| src_pd_tri_i | input | 1 | Power-down mode of the SRC group |
| dot_pd_tri_i | input | 1 | Power-down mode of the 96 MHz pair |
| pd_req_i | input | 1 | Asynchronous active-high power-down request |
| pll_pd_i | input | 3 | Register shut-off per PLL (CPU, SRC, 48/96 MHz) |
| run_o | output | NOUT | Output toggles |
| low_o | output | NOUT | Output driven low |
| hiz_o | output | NOUT | Output tri-stated |
| pll_off_o | output | 3 | PLL shut-off requests |

## Verification
Random register settings are applied in the running state with the stop bit both asserted and deasserted. These runs separate the stoppable outputs from the free-running ones, the tri-state idle choice from the low one, and enabled outputs from disabled ones. Power-down cycles with random drive-mode bits show whether each output class takes its own power-down mode, and whether the PLL shut-off waits for the outputs to settle and releases into a driven-low lock interval. A directed case holds every phase high while the configuration changes. Mode changes must then be deferred until the phase drops, which tells correct edge-aligned gating apart from immediate switching.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  localparam int NUM_PLL = 3;

  typedef enum logic [1:0] {
    MODE_RUN = 2'd0,
    MODE_LOW = 2'd1,
    MODE_HIZ = 2'd2
  } gate_mode_e;

  typedef enum logic [2:0] {
    CLS_CPU, CLS_SRC, CLS_PCIF, CLS_PCI, CLS_REF, CLS_USB, CLS_DOT
  } out_class_e;

  typedef enum logic [1:0] {
    SEQ_WAKE, SEQ_ACTIVE, SEQ_DRAIN, SEQ_OFF
  } seq_state_e;

  // Class of an output index, following the fixed index order.
  function automatic out_class_e class_of(int idx, int ncpu, int nsrc,
                                          int npcif, int npci, int nref);
    if (idx < ncpu) return CLS_CPU;
    if (idx < ncpu + nsrc) return CLS_SRC;
    if (idx < ncpu + nsrc + npcif) return CLS_PCIF;
    if (idx < ncpu + nsrc + npcif + npci) return CLS_PCI;
    if (idx < ncpu + nsrc + npcif + npci + nref) return CLS_REF;
    if (idx == ncpu + nsrc + npcif + npci + nref) return CLS_USB;
    return CLS_DOT;
  endfunction

  function automatic gate_mode_e idle_mode(logic tri_sel);
    return tri_sel ? MODE_HIZ : MODE_LOW;
  endfunction

  // Mode taken while the PLLs are being (or are) shut down.
  function automatic gate_mode_e pd_mode(out_class_e c, logic pd_tri);
    case (c)
      CLS_CPU, CLS_SRC, CLS_DOT: return idle_mode(pd_tri);
      CLS_USB:                   return MODE_HIZ;
      default:                   return MODE_LOW;
    endcase
  endfunction

  // Mode taken while the stop bit is asserted.
  function automatic gate_mode_e stop_mode(out_class_e c, logic stoppable,
                                           logic stop_tri);
    case (c)
      CLS_SRC:  return stoppable ? idle_mode(stop_tri) : MODE_RUN;
      CLS_PCIF: return stoppable ? MODE_LOW : MODE_RUN;
      CLS_PCI:  return MODE_LOW;
      default:  return MODE_RUN;
    endcase
  endfunction

  function automatic gate_mode_e target_mode(out_class_e c, logic en,
                                             logic stoppable, logic stop_act,
                                             logic pd_force, logic wake_force,
                                             logic pd_tri, logic stop_tri);
    if (!en) return MODE_HIZ;
    if (wake_force) return MODE_LOW;
    if (pd_force) return pd_mode(c, pd_tri);
    if (stop_act) return stop_mode(c, stoppable, stop_tri);
    return MODE_RUN;
  endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter bit RST_VAL = 1'b0,
  parameter int STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgate_seq.sv
module clkgate_seq
  import clkgate_pkg::*;
#(
  parameter int LOCK_CYC = 16,
  localparam int CW = $clog2(LOCK_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_sync,
  input  logic       all_settled,
  output seq_state_e state_o,
  output logic       pd_force,
  output logic       wake_force,
  output logic       off_o
);
  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_done;

  assign lock_done = (cnt_q == CW'(LOCK_CYC - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_WAKE: begin
        cnt_d = cnt_q + 1'b1;
        if (pd_sync)        state_d = SEQ_DRAIN;
        else if (lock_done) state_d = SEQ_ACTIVE;
      end
      SEQ_ACTIVE: if (pd_sync) state_d = SEQ_DRAIN;
      SEQ_DRAIN:  if (all_settled) state_d = SEQ_OFF;
      SEQ_OFF: begin
        if (!pd_sync) begin
          state_d = SEQ_WAKE;
          cnt_d   = '0;
        end
      end
      default: state_d = SEQ_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o    = state_q;
  assign pd_force   = (state_q == SEQ_DRAIN) || (state_q == SEQ_OFF);
  assign wake_force = (state_q == SEQ_WAKE);
  assign off_o      = (state_q == SEQ_OFF);
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane
  import clkgate_pkg::*;
#(
  parameter out_class_e CLS = CLS_CPU
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase,
  input  logic       out_en,
  input  logic       stoppable,
  input  logic       stop_act,
  input  logic       pd_force,
  input  logic       wake_force,
  input  logic       pd_tri,
  input  logic       stop_tri,
  output gate_mode_e mode_o,
  output logic       settled_o
);
  gate_mode_e tgt, mode_q;

  assign tgt = target_mode(CLS, out_en, stoppable, stop_act, pd_force,
                           wake_force, pd_tri, stop_tri);

  // New mode is taken only when the divided clock is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_LOW;
    else if (!phase) mode_q <= tgt;
  end

  assign mode_o    = mode_q;
  assign settled_o = (mode_q == tgt);
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int NUM_CPU  = 2,
  parameter int NUM_SRC  = 8,
  parameter int NUM_PCIF = 3,
  parameter int NUM_PCI  = 6,
  parameter int NUM_REF  = 2,
  parameter int LOCK_CYC = 16,
  localparam int NOUT = NUM_CPU + NUM_SRC + NUM_PCIF + NUM_PCI + NUM_REF + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NOUT-1:0]     phase_i,
  input  logic [NOUT-1:0]     out_en_i,
  input  logic [NUM_SRC-1:0]  src_stoppable_i,
  input  logic [NUM_PCIF-1:0] pcif_stoppable_i,
  input  logic                stop_n_i,
  input  logic                src_stop_tri_i,
  input  logic [NUM_CPU-1:0]  cpu_pd_tri_i,
  input  logic                src_pd_tri_i,
  input  logic                dot_pd_tri_i,
  input  logic                pd_req_i,
  input  logic [2:0]          pll_pd_i,
  output logic [NOUT-1:0]     run_o,
  output logic [NOUT-1:0]     low_o,
  output logic [NOUT-1:0]     hiz_o,
  output logic [2:0]          pll_off_o
);
  localparam int SRC_BASE  = NUM_CPU;
  localparam int PCIF_BASE = SRC_BASE + NUM_SRC;

  logic stop_sync, pd_sync;
  logic pd_force, wake_force, seq_off_w, seq_wake_w;
  seq_state_e seq_state;
  logic [NOUT-1:0] settled;

  clkgate_sync #(.RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(stop_n_i), .q(stop_sync));
  clkgate_sync #(.RST_VAL(1'b0)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_req_i), .q(pd_sync));

  clkgate_seq #(.LOCK_CYC(LOCK_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_sync(pd_sync), .all_settled(&settled),
    .state_o(seq_state), .pd_force(pd_force), .wake_force(wake_force),
    .off_o(seq_off_w));

  assign seq_wake_w = (seq_state == SEQ_WAKE);

  for (genvar g = 0; g < NOUT; g++) begin : g_lane
    localparam out_class_e C =
      class_of(g, NUM_CPU, NUM_SRC, NUM_PCIF, NUM_PCI, NUM_REF);
    logic stp, ptri;
    gate_mode_e m;

    if (C == CLS_SRC) begin : g_src
      assign stp  = src_stoppable_i[g - SRC_BASE];
      assign ptri = src_pd_tri_i;
    end else if (C == CLS_PCIF) begin : g_pcif
      assign stp  = pcif_stoppable_i[g - PCIF_BASE];
      assign ptri = 1'b0;
    end else if (C == CLS_CPU) begin : g_cpu
      assign stp  = 1'b0;
      assign ptri = cpu_pd_tri_i[g];
    end else if (C == CLS_DOT) begin : g_dot
      assign stp  = 1'b0;
      assign ptri = dot_pd_tri_i;
    end else begin : g_fixed
      assign stp  = 1'b0;
      assign ptri = 1'b0;
    end

    clkgate_lane #(.CLS(C)) u_lane (
      .clk(clk), .rst_n(rst_n), .phase(phase_i[g]), .out_en(out_en_i[g]),
      .stoppable(stp), .stop_act(!stop_sync), .pd_force(pd_force),
      .wake_force(wake_force), .pd_tri(ptri), .stop_tri(src_stop_tri_i),
      .mode_o(m), .settled_o(settled[g]));

    assign run_o[g] = (m == MODE_RUN);
    assign low_o[g] = (m == MODE_LOW);
    assign hiz_o[g] = (m == MODE_HIZ);
  end

  assign pll_off_o = pll_pd_i | {NUM_PLL{seq_off_w}};
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
  parameter int NOUT = 23
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NOUT-1:0] phase,
  input logic [NOUT-1:0] out_en,
  input logic [NOUT-1:0] run,
  input logic [NOUT-1:0] low,
  input logic [NOUT-1:0] hiz,
  input logic            seq_off,
  input logic            seq_wake
);
  // R1
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((run & low) | (run & hiz) | (low & hiz)) == '0) && ((run | low | hiz) == '1));

  // R4
  phase_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      ((((run ^ $past(run)) | (low ^ $past(low)) | (hiz ^ $past(hiz)))
        & $past(phase)) == '0));

  // R2
  disabled_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~$past(out_en) & ~$past(phase) & ~hiz) == '0));

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_off |-> (run == '0));

  // R7
  wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wake |-> (run == '0));

  // R7
  wake_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(seq_wake)) |->
      (($past(out_en) & ~$past(phase) & ~low) == '0));
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(.NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_i), .out_en(out_en_i),
  .run(run_o), .low(low_o), .hiz(hiz_o),
  .seq_off(seq_off_w), .seq_wake(seq_wake_w));

// File: tb/clkgate_ctrl_bench.sv
module clkgate_ctrl_bench;
  localparam int NC = 2, NS = 8, NF = 3, NP = 6, NR = 2, LOCK = 16;
  localparam int N = NC + NS + NF + NP + NR + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] phase, ph_hold = '0, out_en = '1;
  logic ph_free = 1'b0;
  logic [NS-1:0] src_stp = '0;
  logic [NF-1:0] pcif_stp = '0;
  logic stop_n = 1'b1, src_stop_tri = 1'b0, src_pd_tri = 1'b0, dot_pd_tri = 1'b0;
  logic [NC-1:0] cpu_pd_tri = '0;
  logic pd_req = 1'b0;
  logic [2:0] pll_pd = '0;
  logic [N-1:0] run, low, hiz;
  logic [2:0] pll_off;
  int total = 0, bad = 0;

  always #4 clk = ~clk;
  always @(negedge clk) phase <= ph_free ? ~phase : ph_hold;

  clkgate_ctrl #(.NUM_CPU(NC), .NUM_SRC(NS), .NUM_PCIF(NF), .NUM_PCI(NP),
                 .NUM_REF(NR), .LOCK_CYC(LOCK)) u_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .out_en_i(out_en),
    .src_stoppable_i(src_stp), .pcif_stoppable_i(pcif_stp), .stop_n_i(stop_n),
    .src_stop_tri_i(src_stop_tri), .cpu_pd_tri_i(cpu_pd_tri),
    .src_pd_tri_i(src_pd_tri), .dot_pd_tri_i(dot_pd_tri), .pd_req_i(pd_req),
    .pll_pd_i(pll_pd), .run_o(run), .low_o(low), .hiz_o(hiz), .pll_off_o(pll_off));

  // Expected mode: 0 run, 1 low, 2 tri-state. st: 0 running, 1 powered down, 2 waking.
  function automatic int exp_code(int i, int st);
    if (!out_en[i]) return 2;
    if (st == 2) return 1;
    if (st == 1) begin
      if (i < NC) return cpu_pd_tri[i] ? 2 : 1;
      if (i < NC + NS) return src_pd_tri ? 2 : 1;
      if (i < N - 2) return 1;
      if (i == N - 2) return 2;
      return dot_pd_tri ? 2 : 1;
    end
    if (!stop_n) begin
      if (i >= NC && i < NC + NS && src_stp[i - NC]) return src_stop_tri ? 2 : 1;
      if (i >= NC + NS && i < NC + NS + NF && pcif_stp[i - NC - NS]) return 1;
      if (i >= NC + NS + NF && i < NC + NS + NF + NP) return 1;
    end
    return 0;
  endfunction

  task automatic check_modes(string req, int st);
    logic [N-1:0] er, el, eh;
    for (int i = 0; i < N; i++) begin
      int c = exp_code(i, st);
      er[i] = (c == 0); el[i] = (c == 1); eh[i] = (c == 2);
    end
    total++;
    if (run !== er || low !== el || hiz !== eh) begin
      bad++;
      $display("FAIL %s: run=%h low=%h hiz=%h expected run=%h low=%h hiz=%h",
               req, run, low, hiz, er, el, eh);
    end
  endtask

  task automatic check_pll(string req, logic [2:0] exp);
    total++;
    if (pll_off !== exp) begin
      bad++;
      $display("FAIL %s: pll_off=%b expected %b", req, pll_off, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pd_cycle();
    pd_req = 1'b1;
    cycles(14);
    check_modes("R5 power-down modes", 1);
    check_pll("R6 all PLLs off", 3'b111 | pll_pd);
    pd_req = 1'b0;
    cycles(5);
    check_modes("R7 driven low while waking", 2);
    check_pll("R7 PLLs back on", pll_pd);
    cycles(LOCK + 10);
    check_modes("R7 resumed", 0);
  endtask

  initial begin
    logic [N-1:0] sr, sl, sh;
    void'($urandom(32'h5eed_c10c));
    cycles(3);
    check_modes("R8 reset state", 2);
    check_pll("R8 reset PLL state", 3'b000);
    #1 ph_free = 1'b1;
    cycles(2);
    rst_n = 1'b1;
    cycles(5);
    check_modes("R8 lock interval after reset", 2);
    cycles(LOCK + 10);
    check_modes("R1 all outputs running", 0);

    // R9 per-PLL register shut-off
    pll_pd = 3'b101; cycles(1); check_pll("R9 pll bits 101", 3'b101);
    pll_pd = 3'b010; cycles(1); check_pll("R9 pll bits 010", 3'b010);
    check_modes("R9 outputs unaffected", 0);
    pll_pd = 3'b000; cycles(1);

    // R3 directed stop
    src_stp = 8'hA5; pcif_stp = 3'b010; src_stop_tri = 1'b1; stop_n = 1'b0;
    cycles(8); check_modes("R3 stop, tri-stated SRC", 0);
    src_stop_tri = 1'b0;
    cycles(6); check_modes("R3 stop, low SRC", 0);

    // R4 mode held while phase stays high
    #1 ph_hold = '1; ph_free = 1'b0;
    @(negedge clk);
    cycles(2);
    sr = run; sl = low; sh = hiz;
    stop_n = 1'b1; src_stop_tri = 1'b1;
    cycles(6);
    total++;
    if (run !== sr || low !== sl || hiz !== sh) begin
      bad++;
      $display("FAIL R4 hold: run=%h low=%h hiz=%h expected run=%h low=%h hiz=%h",
               run, low, hiz, sr, sl, sh);
    end
    #1 ph_hold = '0;
    cycles(3);
    check_modes("R4 applied after phase low", 0);
    #1 ph_free = 1'b1;

    // Power-down corner: everything tri-state capable set to tri-state
    cpu_pd_tri = '1; src_pd_tri = 1'b1; dot_pd_tri = 1'b1;
    cycles(2);
    pd_cycle();

    // Random configurations
    for (int it = 0; it < 30; it++) begin
      out_en       = N'({$urandom, $urandom} | {$urandom, $urandom});
      src_stp      = NS'($urandom);
      pcif_stp     = NF'($urandom);
      stop_n       = 1'($urandom);
      src_stop_tri = 1'($urandom);
      cpu_pd_tri   = NC'($urandom);
      src_pd_tri   = 1'($urandom);
      dot_pd_tri   = 1'($urandom);
      cycles(8);
      check_modes(stop_n ? "R2 random running" : "R3 random stopped", 0);
      if (it % 3 == 0) pd_cycle();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule